// File: doc/BRIEF.md
# Packed compare, select and add unit

This is a purely combinational SIMD datapath. It works on two 64-bit operands that are split into lanes of 8, 16 or 32 bits. Each lane is computed on its own. The unit can test lanes for equality, test for greater-than with a signed or an unsigned view, pick the smaller or larger lane with a signed or an unsigned view, add or subtract modulo the lane width, or take the unsigned average of the two lanes with an optional round-up. There is no saturation, and no carry crosses a lane boundary.

Next to the 64-bit result, the unit produces a 32-bit word of negative and zero flags, one pair per lane. The bit positions of each pair depend on the lane width. The word has no register inside the unit: the pipeline stage that follows captures it together with the result and writes both to the register file. The unit has no clock and no state.

Top module: `pcsa_unit`

## Requirements
- R1: With op 0 (equality), each lane of the result is all ones when the lanes of A and B are equal, and all zeros otherwise.
- R2: Op 1 gives all ones in a lane where A > B with both lanes read as two's complement. Op 2 does the same with both lanes read as unsigned. Otherwise the lane is all zeros, so 8-bit lanes 0x80 and 0x7F give 0x00 under op 1 and 0xFF under op 2.
- R3: Ops 3, 4, 5 and 6 each place in every lane either the A lane or the B lane. Op 3 takes the signed minimum, op 4 the unsigned minimum, op 5 the signed maximum and op 6 the unsigned maximum.
- R4: Op 7 gives A+B and op 8 gives A-B in every lane, modulo 2^W. There is no saturation and no carry or borrow into the next lane, so 8-bit lanes 0xFF+0x01 give 0x00 and leave the neighbouring lane unchanged.
- R5: Op 9 gives the unsigned average (a+b+r)>>1 for each lane, where r is round_i. The sum is formed one bit wider than the lane, so 0xFF and 0xFF with r=1 give 0xFF. Op 9 exists only for size 0 and size 1. With size 2, op 9 gives a result of zero and a flag word of zero.
- R6: size_i selects the lane width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits. For lane k of width W, the N flag is flag bit k*W/2+W/2-1 and the Z flag is flag bit k*W/2+W/2-2. That puts N and Z for byte lane i at bits 4i+3 and 4i+2, for halfword lane h at bits 8h+7 and 8h+6, and for word lane w at bits 16w+15 and 16w+14.
- R7: N is the top bit of the lane's result. Z is 1 exactly when the lane's result is zero.
- R8: The average operation sets Z flags only. All N flag bits read 0 for op 9.
- R9: Every flag bit that is not an N or Z position for the selected lane width reads 0.
- R10: For size 3, or for an op code above 9, the result is zero and the flag word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand |
| op_i | input | 4 | Operation code, 0 to 9 (see R1 to R5) |
| size_i | input | 2 | Lane width select: 0 for 8, 1 for 16, 2 for 32 bits |
| round_i | input | 1 | Round-up for the average |
| result_o | output | 64 | Packed result |
| flags_o | output | 32 | Per-lane negative and zero flags |

## Verification
The unit holds no state, so a fault in a lane slice, in a comparator's sign handling or in the width mux shows on result_o or flags_o as soon as the inputs settle. It also shows only for the lane width and op that reach the faulty logic. The bench therefore sweeps every op against every size with operands that put the top bit of a lane on the signed/unsigned boundary, carry out of a lane, and leave a lane zero. A flag placed at the wrong position shows up as a wrong nibble pattern in flags_o, even when the result itself is correct.

// File: rtl/pcsa_pkg.sv
package pcsa_pkg;
  localparam int DATA_W     = 64;
  localparam int FLAG_W     = DATA_W / 2;
  localparam int MIN_LANE_W = 8;
  localparam int NUM_SIZES  = 3;
  localparam int AVG_MAX_W  = 16;

  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_GTS  = 4'd1,
    OP_GTU  = 4'd2,
    OP_MINS = 4'd3,
    OP_MINU = 4'd4,
    OP_MAXS = 4'd5,
    OP_MAXU = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_AVG  = 4'd9
  } op_e;
endpackage

// File: rtl/pcsa_lane.sv
module pcsa_lane #(
  parameter int W      = 8,
  parameter bit AVG_OK = 1'b1
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  pcsa_pkg::op_e  op_i,
  input  logic           round_i,
  output logic [W-1:0]   res_o
);
  import pcsa_pkg::*;

  logic [W:0] avg_sum;
  logic       lt_s, lt_u;

  assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, round_i};
  assign lt_s    = $signed(a_i) < $signed(b_i);
  assign lt_u    = a_i < b_i;

  always_comb begin
    unique case (op_i)
      OP_EQ:   res_o = {W{a_i == b_i}};
      OP_GTS:  res_o = {W{$signed(a_i) > $signed(b_i)}};
      OP_GTU:  res_o = {W{a_i > b_i}};
      OP_MINS: res_o = lt_s ? a_i : b_i;
      OP_MINU: res_o = lt_u ? a_i : b_i;
      OP_MAXS: res_o = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
      OP_MAXU: res_o = (a_i > b_i) ? a_i : b_i;
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AVG:  res_o = AVG_OK ? avg_sum[W:1] : '0;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/pcsa_flags.sv
module pcsa_flags #(
  parameter int W      = 8,
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic              z_only_i,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int LANES = DATA_W / W;
  localparam int SPAN  = FLAG_W / LANES;

  always_comb begin
    flags_o = '0;
    for (int k = 0; k < LANES; k++) begin
      flags_o[k*SPAN + SPAN - 1] = ~z_only_i & res_i[k*W + W - 1];
      flags_o[k*SPAN + SPAN - 2] = (res_i[k*W +: W] == '0);
    end
  end
endmodule

// File: rtl/pcsa_unit.sv
module pcsa_unit
  import pcsa_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              round_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  op_e  op;
  logic is_avg;
  logic valid;

  assign op     = op_e'(op_i);
  assign is_avg = (op_i == OP_AVG);

  logic [DATA_W-1:0] res_s [NUM_SIZES];
  logic [FLAG_W-1:0] flg_s [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W     = MIN_LANE_W << s;
    localparam int LANES = DATA_W / W;
    logic [DATA_W-1:0] r;
    logic [FLAG_W-1:0] f;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
      pcsa_lane #(.W(W), .AVG_OK(W <= AVG_MAX_W)) u_lane (
        .a_i    (a_i[k*W +: W]),
        .b_i    (b_i[k*W +: W]),
        .op_i   (op),
        .round_i(round_i),
        .res_o  (r[k*W +: W])
      );
    end

    pcsa_flags #(.W(W), .DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_flags (
      .res_i   (r),
      .z_only_i(is_avg),
      .flags_o (f)
    );

    assign res_s[s] = r;
    assign flg_s[s] = f;
  end

  always_comb begin
    valid = (int'(size_i) < NUM_SIZES) && (op_i <= OP_AVG);
    if (is_avg && ((MIN_LANE_W << size_i) > AVG_MAX_W)) valid = 1'b0;
    result_o = '0;
    flags_o  = '0;
    if (valid) begin
      for (int s = 0; s < NUM_SIZES; s++) begin
        if (int'(size_i) == s) begin
          result_o = res_s[s];
          flags_o  = flg_s[s];
        end
      end
    end
  end
endmodule

// File: rtl/pcsa_unit_chk.sv
module pcsa_unit_chk (
  input logic [63:0] a_i,
  input logic [63:0] b_i,
  input logic [3:0]  op_i,
  input logic [1:0]  size_i,
  input logic        round_i,
  input logic [63:0] result_o,
  input logic [31:0] flags_o
);
  always_comb begin
    if (size_i == 2'd3 || op_i > 4'd9) begin
      a_r10_bad_code_zero: assert (result_o == '0 && flags_o == '0)
        else $error("R10 unsupported code gave nonzero output");
    end
    if (size_i == 2'd2) begin
      a_r9_word_flags: assert ((flags_o & 32'h3FFF3FFF) == '0)
        else $error("R9 stray flag bits at 32-bit lanes");
    end
    if (size_i == 2'd1) begin
      a_r9_half_flags: assert ((flags_o & 32'h3F3F3F3F) == '0)
        else $error("R9 stray flag bits at 16-bit lanes");
    end
    if (op_i == 4'd9) begin
      a_r8_avg_n_clear: assert ((flags_o & 32'h88888888) == '0)
        else $error("R8 N flag set by average");
    end
    if (op_i == 4'd0 && size_i == 2'd0) begin
      for (int k = 0; k < 8; k++) begin
        a_r1_lane_full: assert (result_o[k*8 +: 8] == 8'h00 || result_o[k*8 +: 8] == 8'hFF)
          else $error("R1 partial compare lane %0d", k);
      end
    end
    if (op_i >= 4'd3 && op_i <= 4'd6 && size_i == 2'd0) begin
      for (int k = 0; k < 8; k++) begin
        a_r3_pick_operand: assert (result_o[k*8 +: 8] == a_i[k*8 +: 8] ||
                                   result_o[k*8 +: 8] == b_i[k*8 +: 8])
          else $error("R3 lane %0d is neither operand", k);
      end
    end
    if (size_i == 2'd0 && op_i <= 4'd9) begin
      for (int k = 0; k < 8; k++) begin
        a_r7_zero_flag: assert (flags_o[4*k+2] == (result_o[k*8 +: 8] == 8'h00))
          else $error("R7 Z flag mismatch lane %0d", k);
      end
    end
  end
endmodule

bind pcsa_unit pcsa_unit_chk u_chk (.*);

// File: tb/pcsa_unit_tb_top.sv
`timescale 1ns/1ps
module pcsa_unit_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] a = '0, b = '0;
  logic [3:0]  op = 4'd7;
  logic [1:0]  size = 2'd0;
  logic        rnd = 1'b0;
  logic [63:0] result;
  logic [31:0] flags;

  pcsa_unit dut_i (
    .a_i(a), .b_i(b), .op_i(op), .size_i(size), .round_i(rnd),
    .result_o(result), .flags_o(flags)
  );

  typedef struct {
    logic [63:0] res;
    logic [31:0] fl;
    string       tr;
    string       tf;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int checks = 0, fails = 0;

  function automatic void model(input int o, input int sz, input logic [63:0] x,
                                input logic [63:0] y, input bit r,
                                output logic [63:0] res, output logic [31:0] fl);
    int w;
    longint unsigned mask, la, lb, lr;
    longint sa, sb_;
    res = '0;
    fl  = '0;
    if (sz > 2 || o > 9 || (o == 9 && sz == 2)) return;
    w = 8 << sz;
    mask = (64'd1 << w) - 1;
    for (int k = 0; k < 64 / w; k++) begin
      la = (x >> (k * w)) & mask;
      lb = (y >> (k * w)) & mask;
      sa  = la[w-1] ? longint'(la) - longint'(64'd1 << w) : longint'(la);
      sb_ = lb[w-1] ? longint'(lb) - longint'(64'd1 << w) : longint'(lb);
      case (o)
        0: lr = (la == lb) ? mask : 0;
        1: lr = (sa > sb_) ? mask : 0;
        2: lr = (la > lb) ? mask : 0;
        3: lr = (sa < sb_) ? la : lb;
        4: lr = (la < lb) ? la : lb;
        5: lr = (sa > sb_) ? la : lb;
        6: lr = (la > lb) ? la : lb;
        7: lr = (la + lb) & mask;
        8: lr = (la - lb) & mask;
        default: lr = (la + lb + longint'(r)) >> 1;
      endcase
      res = res | (64'(lr) << (k * w));
      if (o != 9) fl[k*w/2 + w/2 - 1] = lr[w-1];
      fl[k*w/2 + w/2 - 2] = (lr == 0);
    end
  endfunction

  task automatic apply(input int o, input int sz, input logic [63:0] x,
                       input logic [63:0] y, input bit r);
    exp_t e;
    @(posedge clk);
    #1;
    a = x; b = y; op = 4'(o); size = 2'(sz); rnd = r;
    model(o, sz, x, y, r, e.res, e.fl);
    if (sz > 2 || o > 9 || (o == 9 && sz == 2)) begin
      e.tr = (o == 9 && sz == 2) ? "R5" : "R10";
      e.tf = e.tr;
    end else begin
      case (o)
        0: e.tr = "R1";
        1, 2: e.tr = "R2";
        3, 4, 5, 6: e.tr = "R3";
        7, 8: e.tr = "R4";
        default: e.tr = "R5";
      endcase
      if (o == 9) e.tf = "R8 R6";
      else if (sz == 2) e.tf = "R9 R6 R7";
      else if (sz == 1) e.tf = "R9 R6 R7";
      else e.tf = "R6 R7";
    end
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks++;
      if (result !== cur.res) begin
        fails++;
        $display("FAIL %s result op=%0d size=%0d actual=%h expected=%h",
                 cur.tr, op, size, result, cur.res);
      end
      checks++;
      if (flags !== cur.fl) begin
        fails++;
        $display("FAIL %s flags op=%0d size=%0d actual=%h expected=%h",
                 cur.tf, op, size, flags, cur.fl);
      end
    end
  end

  logic [63:0] pa [6] = '{64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                          64'h807F_0001_FF00_8000, 64'h1234_5678_9ABC_DEF0,
                          64'h7FFF_FFFF_8000_0000, 64'h00FF_7F80_0102_FE01};
  logic [63:0] pb [6] = '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001,
                          64'h7F80_0001_00FF_7FFF, 64'h1234_0000_9ABD_DEEF,
                          64'h8000_0000_7FFF_FFFF, 64'h0001_807F_0102_0203};

  initial begin
    // idle zero operands: every byte lane Z flag set
    apply(7, 0, 64'h0, 64'h0, 1'b0);
    // R4 byte wrap, no carry into the next lane
    apply(7, 0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1'b0);
    apply(8, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0);
    // R2 signed versus unsigned at 0x80 / 0x7F
    apply(1, 0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_007F, 1'b0);
    apply(2, 0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_007F, 1'b0);
    // R5 widest sum with round-up
    apply(9, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    apply(9, 1, 64'h0001_0003_FFFF_0000, 64'h0000_0000_FFFF_0001, 1'b0);
    apply(9, 1, 64'h0001_0003_FFFF_0000, 64'h0000_0000_FFFF_0001, 1'b1);
    apply(9, 2, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444, 1'b1);
    // R10 undefined encodings
    apply(7, 3, 64'h1, 64'h1, 1'b0);
    for (int o = 10; o < 16; o++) apply(o, 0, 64'h55, 64'h0, 1'b0);
    // sweep: every op at every size
    for (int o = 0; o < 10; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int p = 0; p < 6; p++)
          for (int r = 0; r < 2; r++) begin
            apply(o, sz, pa[p], pb[p], r[0]);
            apply(o, sz, pb[p], pa[p], r[0]);
          end
    @(posedge clk);
    @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule